// File: doc/BRIEF.md
# Double-Buffered Configuration Shift Chain

This block holds the configuration of an array of reconfigurable elements as a serial chain of program stages. Every stage pairs a shadow (preload) word with an active word. Configuration words stream in at the head of the chain. Each accepted word pushes every preload word one stage further toward the tail. The active words drive the elements and do not move during loading, so the array keeps running its present function while the next one is loaded.

When a full configuration sits in the preload words, a single commit strobe copies all of them into the active words on one clock edge. The whole array therefore switches function in one cycle. The preload word of the last stage is visible at a tail port, so a loaded image can be shifted out and compared.

The loading interface is valid/ready. The chain signals ready exactly while programming mode is enabled. A word is accepted on a clock edge where both valid and ready are high. When ready is low, the source must hold its word and valid until it is accepted. The mode and commit pins are plain levels.

Top module: `cfg_shift_chain`

## Requirements
- R1: An accepted word enters stage 0, and on the same edge stage k's preload word moves into stage k+1. `cfg_tail` always shows the preload word of stage STAGES-1.
- R2: `in_ready` equals `prog_en`. Preload words change only on an edge where `prog_en` and `in_valid` are both high. A word offered while `prog_en` is low is ignored.
- R3: Active words keep their value on every edge where `commit` is low, including edges where words are being shifted.
- R4: On an edge with `commit` high, every stage's active word loads its preload word. Stage k's active word appears on `cfg_out[k*WORD_W +: WORD_W]`.
- R5: When `commit` and an accepted word fall on the same edge, the active words take the preload values from before that shift.
- R6: After a reset, the first accepted word appears on `cfg_tail` after exactly STAGES accepted words, and not after STAGES-1.
- R7: A synchronous reset (`rst_n` low at an edge) clears all preload and active words to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_en | input | 1 | Programming mode enable |
| in_valid | input | 1 | Configuration word on `in_data` is valid |
| in_ready | output | 1 | Chain can accept a word |
| in_data | input | WORD_W | Configuration word for the head of the chain |
| commit | input | 1 | Copy all preload words into the active words |
| cfg_tail | output | WORD_W | Preload word of the last stage (readback) |
| cfg_out | output | STAGES*WORD_W | Active configuration words, stage k in slice k |

## Verification
The bench builds the chain with 16-bit words and four stages. With these values, a full load, a readback at the tail and the arrival of the first word at the tail all happen within a few clocks. The first and last stages can be checked individually, along with every slice of the active output. Commits both with and without a concurrent shift are covered, as are stalls, words offered outside programming mode and a reset in the middle of a load.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_STAGES = 128;
endpackage

// File: rtl/cfg_shift_gate.sv
module cfg_shift_gate (
  input  logic prog_en,
  input  logic in_valid,
  output logic in_ready,
  output logic shift_en
);
  always_comb begin
    in_ready = prog_en;
    shift_en = prog_en && in_valid;
  end
endmodule

// File: rtl/cfg_stage.sv
module cfg_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              commit,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] preload,
  output logic [WORD_W-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload <= '0;
      active  <= '0;
    end else begin
      if (shift_en) preload <= din;
      if (commit)   active  <= preload;
    end
  end

  a_r1_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> preload == $past(din));
  a_r2_preload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(preload));
  a_r3_active_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));
  // R4 and R5: the value captured is the preload word before any same-edge shift
  a_r4_commit_load: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active == $past(preload));
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int unsigned WORD_W = cfgchain_pkg::DEF_WORD_W,
  parameter int unsigned STAGES = cfgchain_pkg::DEF_STAGES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_en,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WORD_W-1:0]        in_data,
  input  logic                     commit,
  output logic [WORD_W-1:0]        cfg_tail,
  output logic [STAGES*WORD_W-1:0] cfg_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic shift_en;
  logic [WORD_W-1:0] pre_q [STAGES];
  logic [WORD_W-1:0] act_q [STAGES];

  cfg_shift_gate u_gate (
    .prog_en  (prog_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .shift_en (shift_en)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [WORD_W-1:0] feed;
    if (k == 0) begin : g_head
      assign feed = in_data;
    end else begin : g_link
      assign feed = pre_q[k-1];
    end
    cfg_stage #(.WORD_W(WORD_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .commit   (commit),
      .din      (feed),
      .preload  (pre_q[k]),
      .active   (act_q[k])
    );
    assign cfg_out[k*WORD_W +: WORD_W] = act_q[k];
  end

  assign cfg_tail = pre_q[LAST];

  a_r7_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (cfg_tail == '0 && cfg_out == '0));
  a_r2_ready_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(cfg_tail));
endmodule

// File: tb/test_cfg_shift_chain.sv
module test_cfg_shift_chain;
  localparam int W = 16;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_en = 1'b0;
  logic in_valid = 1'b0;
  logic commit = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready;
  logic [W-1:0] cfg_tail;
  logic [N*W-1:0] cfg_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_shift_chain #(.WORD_W(W), .STAGES(N)) i_cfg_shift_chain (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .commit(commit),
    .cfg_tail(cfg_tail), .cfg_out(cfg_out)
  );

  // prog, valid, data, commit, exp_tail, exp_act0, exp_act3
  typedef struct packed {
    logic prog; logic vld; logic [W-1:0] d; logic cm;
    logic [W-1:0] tail; logic [W-1:0] a0; logic [W-1:0] a3;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 16'h1111, 1'b0, 16'h0000, 16'h0000, 16'h0000}, // R1
    '{1'b1, 1'b1, 16'h2222, 1'b0, 16'h0000, 16'h0000, 16'h0000}, // R3
    '{1'b1, 1'b1, 16'h3333, 1'b0, 16'h0000, 16'h0000, 16'h0000}, // R6
    '{1'b1, 1'b1, 16'h4444, 1'b0, 16'h1111, 16'h0000, 16'h0000}, // R6
    '{1'b1, 1'b0, 16'h9999, 1'b0, 16'h1111, 16'h0000, 16'h0000}, // R2 stall
    '{1'b0, 1'b1, 16'h5555, 1'b0, 16'h1111, 16'h0000, 16'h0000}, // R2 ignored
    '{1'b0, 1'b0, 16'h0000, 1'b1, 16'h1111, 16'h4444, 16'h1111}, // R4
    '{1'b1, 1'b1, 16'hAAAA, 1'b0, 16'h2222, 16'h4444, 16'h1111}, // R3
    '{1'b1, 1'b1, 16'hBBBB, 1'b1, 16'h3333, 16'hAAAA, 16'h2222}, // R5
    '{1'b0, 1'b0, 16'h0000, 1'b0, 16'h3333, 16'hAAAA, 16'h2222}  // R3
  };

  task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic v, input logic [W-1:0] d, input logic c);
    prog_en = p; in_valid = v; in_data = d; commit = c;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    check("R7", {{(N-1)*W{1'b0}}, cfg_tail}, '0);
    check("R7", cfg_out, '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].prog, VEC[i].vld, VEC[i].d, VEC[i].cm);
      #1;
      check("R2", {{(N*W-1){1'b0}}, in_ready}, {{(N*W-1){1'b0}}, VEC[i].prog});
      @(negedge clk);
      check("R1", {{(N-1)*W{1'b0}}, cfg_tail}, {{(N-1)*W{1'b0}}, VEC[i].tail});
      check("R4", {{(N-1)*W{1'b0}}, cfg_out[0 +: W]}, {{(N-1)*W{1'b0}}, VEC[i].a0});
      check("R4", {{(N-1)*W{1'b0}}, cfg_out[(N-1)*W +: W]}, {{(N-1)*W{1'b0}}, VEC[i].a3});
    end
    // R5: full active image after commit with concurrent shift
    check("R5", cfg_out, {16'h2222, 16'h3333, 16'h4444, 16'hAAAA});

    // R7: reset in the middle of a load clears both layers
    drive(1'b1, 1'b1, 16'hCCCC, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 16'h0000, 1'b1);
    @(negedge clk);
    check("R7", cfg_out, '0);
    check("R7", {{(N-1)*W{1'b0}}, cfg_tail}, '0);

    // R6: first word reaches the tail after exactly N accepted words
    for (int k = 0; k < N; k++) begin
      drive(1'b1, 1'b1, W'(16'h0A00 + k), 1'b0);
      @(negedge clk);
      if (k == N-2) check("R6", {{(N-1)*W{1'b0}}, cfg_tail}, '0);
    end
    check("R6", {{(N-1)*W{1'b0}}, cfg_tail}, {{(N-1)*W{1'b0}}, 16'h0A00});
    // R3: shifting left the cleared active words alone
    check("R3", cfg_out, '0);
    // R1: readback order at the tail
    for (int k = 1; k < N; k++) begin
      drive(1'b1, 1'b1, 16'h0000, 1'b0);
      @(negedge clk);
      check("R1", {{(N-1)*W{1'b0}}, cfg_tail}, {{(N-1)*W{1'b0}}, W'(16'h0A00 + k)});
    end
    drive(1'b0, 1'b0, 16'h0000, 1'b0);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule